// File: doc/BRIEF.md
# Erase-Block Lock Guard

This block guards a small flash-style array that is split into a fixed number of erase blocks, each carrying its own lock bit. A requester presents one operation at a time, together with the level of a protection-lift input. The operation is a block erase, a cell write, a whole-array erase, setting one block's lock, or clearing every lock. The block decides whether the operation may run. It then reports which blocks a completed erase or write touched and updates the lock bits. Outcomes appear in an eight-bit status word that carries a ready flag and sticky error flags.

An accepted operation keeps the block busy for a programmable number of cycles before it completes. An abort input can end a running operation early, and then nothing takes effect. The one exception is an aborted lock clear: every lock bit becomes unknown until a later clear finishes. An unknown lock reads as 1 and is treated as locked. A separate vector marks which locks are unknown. A rejected operation never goes busy and changes no state apart from the status flags.

Top module: `lkp_ctrl`

## Requirements
- R1: After reset, busy_o is 0, status_o is 8'h80, lock_o and lock_unknown_o are all zero, and done_o is 0.
- R2: A block erase (op 1) or a write (op 2) to a block whose effective lock (lock bit OR unknown flag) is 0 is accepted at either level of wp_lift_i; at completion done_mask_o is the one-hot mask of that block.
- R3: A block erase or write to a block whose effective lock is 1, issued with wp_lift_i low, is rejected. busy_o stays 0 and status bit 1 is set, plus bit 5 for an erase or bit 4 for a write. The status word is bit 7 ready (not busy), bit 5 erase/clear failure, bit 4 write/set failure, bit 1 protection failure, and every other bit 0.
- R4: With wp_lift_i high, a locked block is overridden and block erase and write are accepted.
- R5: A whole-array erase (op 3) is always accepted. Its done_mask_o is the inverse of the effective locks when wp_lift_i was low, and all ones when it was high, with both taken at acceptance.
- R6: Setting a lock (op 4) is accepted only with wp_lift_i high and sets that block's lock bit at completion. With wp_lift_i low it is rejected with status bits 1 and 4.
- R7: Clearing locks (op 5) is accepted only with wp_lift_i high, and at completion it zeroes every lock bit and unknown flag. With wp_lift_i low it is rejected with status bits 1 and 5.
- R8: An accepted operation holds busy_o high for max(busy_len_i,1) cycles. done_o is high for exactly one cycle, the first cycle after busy_o falls. done_mask_o is zero for lock operations.
- R9: Requests presented while busy_o is high are ignored.
- R10: An abort during busy drops busy_o in the next cycle with no done_o pulse and no effect. An aborted clear sets every unknown flag, and unknown locks read as 1 on lock_o.
- R11: An abort in the final busy cycle takes precedence over completion.
- R12: Status error bits stay set until clr_status_i is pulsed. A rejection in the same cycle as clr_status_i leaves exactly the new error's bits set.
- R13: A rejection takes effect in one cycle and leaves lock_o, lock_unknown_o and done_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Operation request strobe |
| req_op_i | input | 3 | Operation code: 1 block erase, 2 write, 3 whole-array erase, 4 set lock, 5 clear locks |
| req_blk_i | input | BLK_W | Target block index |
| wp_lift_i | input | 1 | Protection lift: 1 overrides locks and allows lock changes |
| abort_i | input | 1 | Ends the running operation |
| clr_status_i | input | 1 | Clears the status error flags |
| busy_len_i | input | CNT_W | Busy duration in cycles, taken at acceptance (0 means 1) |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 8 | Status word |
| lock_o | output | NUM_BLK | Lock bits as read (unknown reads 1) |
| lock_unknown_o | output | NUM_BLK | Per-block unknown-lock flags |
| done_o | output | 1 | One-cycle completion pulse |
| done_mask_o | output | NUM_BLK | Blocks erased or written by the completing operation |

## Verification
Two collisions can fall in the same cycle. An abort can arrive in the final busy cycle, when completion would otherwise fire, and a rejection can arrive together with a status clear. The bench drives aborts at random and directed busy cycles, including the last one. It then expects no done pulse, an unchanged lock state, or all locks unknown after an aborted clear. It also pulses the status clear alongside random requests and expects only the new rejection's bits to remain.

// File: rtl/lkp_pkg.sv
// Shared types for the erase-block lock guard.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lkp_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_BLK_ERASE  = 3'd1,
        OP_WRITE      = 3'd2,
        OP_CHIP_ERASE = 3'd3,
        OP_SET_LOCK   = 3'd4,
        OP_CLR_LOCKS  = 3'd5
    } lkp_op_e;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_WRITE_ERR = 4;
    localparam int ST_PROT_ERR  = 1;
endpackage

// File: rtl/lkp_decide.sv
// Permission decision for one request: it says whether the request is known
// and allowed, which error class a rejection belongs to, and which blocks the
// operation's cells touch.
// Assumes NUM_BLK is a power of two, so every block index is in range.
module lkp_decide #(
    parameter int NUM_BLK = 8,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic [2:0]         op_i,
    input  logic [BLK_W-1:0]   blk_i,
    input  logic               lift_i,
    input  logic [NUM_BLK-1:0] lock_eff_i,
    output logic               known_o,
    output logic               allowed_o,
    output logic               cls_erase_o,
    output logic               cls_write_o,
    output logic [NUM_BLK-1:0] cell_mask_o
);
    import lkp_pkg::*;

    localparam logic [NUM_BLK-1:0] ONE = {{(NUM_BLK-1){1'b0}}, 1'b1};

    // Apply the protection table to the presented operation.
    always_comb begin
        known_o     = 1'b1;
        allowed_o   = 1'b0;
        cls_erase_o = 1'b0;
        cls_write_o = 1'b0;
        cell_mask_o = '0;
        case (lkp_op_e'(op_i))
            OP_BLK_ERASE: begin
                allowed_o   = !lock_eff_i[blk_i] || lift_i;
                cls_erase_o = 1'b1;
                cell_mask_o = ONE << blk_i;
            end
            OP_WRITE: begin
                allowed_o   = !lock_eff_i[blk_i] || lift_i;
                cls_write_o = 1'b1;
                cell_mask_o = ONE << blk_i;
            end
            OP_CHIP_ERASE: begin
                allowed_o   = 1'b1;
                cls_erase_o = 1'b1;
                cell_mask_o = lift_i ? '1 : ~lock_eff_i;
            end
            OP_SET_LOCK: begin
                allowed_o   = lift_i;
                cls_write_o = 1'b1;
            end
            OP_CLR_LOCKS: begin
                allowed_o   = lift_i;
                cls_erase_o = 1'b1;
            end
            default: known_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lkp_timer.sv
// Busy timer: once started it holds busy for max(len,1) cycles, then raises
// fire in the last busy cycle. An abort ends busy without fire.
// Assumes start is only raised while busy is low.
module lkp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q;

    assign fire_o = busy_o && (cnt_q == CNT_W'(1)) && !abort_i;

    // Load, count down and terminate the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_o) begin
            if (abort_i || cnt_q == CNT_W'(1)) begin
                busy_o <= 1'b0;
            end
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= (len_i == '0) ? CNT_W'(1) : len_i;
        end
    end

    // R8: busy does not end early without an abort
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !abort_i && cnt_q != CNT_W'(1)) |=> busy_o);
    // R10: an abort ends the busy window at the next edge
    a_r10_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> !busy_o);
    // R11: fire never coincides with an abort
    a_r11_abort_beats_fire: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !fire_o);
endmodule

// File: rtl/lkp_lockbits.sv
// Per-block lock storage with an unknown flag per block. An unknown lock
// reads as 1. Poison (an aborted clear) marks every block unknown and has
// priority over clear and set.
// Assumes at most one of clr/set is raised per cycle.
module lkp_lockbits #(
    parameter int NUM_BLK = 8,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  logic [BLK_W-1:0]   set_blk_i,
    input  logic               clr_i,
    input  logic               poison_i,
    output logic [NUM_BLK-1:0] lock_eff_o,
    output logic [NUM_BLK-1:0] unknown_o
);
    logic [NUM_BLK-1:0] lock_q;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_cell
        logic cell_lock;
        logic cell_unk;

        // Update one block's lock bit and unknown flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_lock <= 1'b0;
                cell_unk  <= 1'b0;
            end else if (poison_i) begin
                cell_unk  <= 1'b1;
            end else if (clr_i) begin
                cell_lock <= 1'b0;
                cell_unk  <= 1'b0;
            end else if (set_i && set_blk_i == BLK_W'(g)) begin
                cell_lock <= 1'b1;
            end
        end

        assign lock_q[g]    = cell_lock;
        assign unknown_o[g] = cell_unk;
    end

    assign lock_eff_o = lock_q | unknown_o;

    // R10: an aborted clear leaves every lock unknown
    a_r10_poison_all: assert property (@(posedge clk) disable iff (!rst_n)
        poison_i |=> (&unknown_o));
    // R7: a completed clear leaves every lock known and open
    a_r7_clear_known: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !poison_i) |=> (lock_eff_o == '0));
    // R13: without an update request the lock state holds
    a_r13_locks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && !poison_i) |=> ($stable(lock_eff_o) && $stable(unknown_o)));
endmodule

// File: rtl/lkp_status.sv
// Status word with sticky error flags. The clear input drops the flags, and
// a rejection in the same cycle sets its own flags on top of the clear.
// Assumes rej_erase/rej_write are only meaningful with rej.
module lkp_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       rej_i,
    input  logic       rej_erase_i,
    input  logic       rej_write_i,
    input  logic       busy_i,
    output logic [7:0] status_o
);
    import lkp_pkg::*;

    logic err_erase_q;
    logic err_write_q;
    logic err_prot_q;

    // Hold, clear and set the error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_erase_q <= 1'b0;
            err_write_q <= 1'b0;
            err_prot_q  <= 1'b0;
        end else begin
            err_erase_q <= (err_erase_q && !clr_i) || (rej_i && rej_erase_i);
            err_write_q <= (err_write_q && !clr_i) || (rej_i && rej_write_i);
            err_prot_q  <= (err_prot_q  && !clr_i) || rej_i;
        end
    end

    // Assemble the status word from the flags.
    always_comb begin
        status_o               = '0;
        status_o[ST_READY]     = !busy_i;
        status_o[ST_ERASE_ERR] = err_erase_q;
        status_o[ST_WRITE_ERR] = err_write_q;
        status_o[ST_PROT_ERR]  = err_prot_q;
    end

    // R12: error flags persist until cleared
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prot_q && !clr_i) |=> err_prot_q);
    // R3: a rejection always raises the protection flag
    a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rej_i |=> err_prot_q);
endmodule

// File: rtl/lkp_ctrl.sv
// Top of the erase-block lock guard. It decides each idle-time request,
// times accepted operations, applies their effects at completion and reports
// status. A rejected request only updates the status flags.
// Assumes NUM_BLK is a power of two and that requests are single-cycle strobes.
module lkp_ctrl #(
    parameter int NUM_BLK = 8,
    parameter int CNT_W   = 8,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [2:0]         req_op_i,
    input  logic [BLK_W-1:0]   req_blk_i,
    input  logic               wp_lift_i,
    input  logic               abort_i,
    input  logic               clr_status_i,
    input  logic [CNT_W-1:0]   busy_len_i,
    output logic               busy_o,
    output logic [7:0]         status_o,
    output logic [NUM_BLK-1:0] lock_o,
    output logic [NUM_BLK-1:0] lock_unknown_o,
    output logic               done_o,
    output logic [NUM_BLK-1:0] done_mask_o
);
    import lkp_pkg::*;

    logic               known, allowed, cls_erase, cls_write;
    logic [NUM_BLK-1:0] cell_mask;
    logic               idle_req, start, rej, fire;
    lkp_op_e            op_q;
    logic [BLK_W-1:0]   blk_q;
    logic [NUM_BLK-1:0] mask_q;

    lkp_decide #(.NUM_BLK(NUM_BLK)) u_decide (
        .op_i        (req_op_i),
        .blk_i       (req_blk_i),
        .lift_i      (wp_lift_i),
        .lock_eff_i  (lock_o),
        .known_o     (known),
        .allowed_o   (allowed),
        .cls_erase_o (cls_erase),
        .cls_write_o (cls_write),
        .cell_mask_o (cell_mask)
    );

    assign idle_req = req_valid_i && !busy_o;
    assign start    = idle_req && known && allowed;
    assign rej      = idle_req && known && !allowed;

    lkp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .len_i   (busy_len_i),
        .abort_i (abort_i),
        .busy_o  (busy_o),
        .fire_o  (fire)
    );

    // Capture the accepted operation and its cell mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            blk_q  <= '0;
            mask_q <= '0;
        end else if (start) begin
            op_q   <= lkp_op_e'(req_op_i);
            blk_q  <= req_blk_i;
            mask_q <= cell_mask;
        end
    end

    lkp_lockbits #(.NUM_BLK(NUM_BLK)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (fire && op_q == OP_SET_LOCK),
        .set_blk_i  (blk_q),
        .clr_i      (fire && op_q == OP_CLR_LOCKS),
        .poison_i   (busy_o && abort_i && op_q == OP_CLR_LOCKS),
        .lock_eff_o (lock_o),
        .unknown_o  (lock_unknown_o)
    );

    lkp_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_status_i),
        .rej_i       (rej),
        .rej_erase_i (cls_erase),
        .rej_write_i (cls_write),
        .busy_i      (busy_o),
        .status_o    (status_o)
    );

    // Emit the completion pulse and the touched-block mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            done_mask_o <= '0;
        end else begin
            done_o      <= fire;
            done_mask_o <= (fire && (op_q == OP_BLK_ERASE || op_q == OP_WRITE ||
                            op_q == OP_CHIP_ERASE)) ? mask_q : '0;
        end
    end

    // R13: a rejection neither starts busy nor completes anything
    a_r13_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> (!busy_o && !done_o));
    // R10: an abort never produces a completion pulse
    a_r10_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> !done_o);
    // R9: a request while busy does not restart or complete the window
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid_i && !abort_i && !fire) |=> busy_o);
    // R3: a locked erase/write with protection active is rejected
    a_r3_locked_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && (req_op_i == 3'd1 || req_op_i == 3'd2) &&
         lock_o[req_blk_i] && !wp_lift_i) |=> (!busy_o && status_o[ST_PROT_ERR]));
endmodule

// File: tb/lkp_ctrl_bench.sv
`timescale 1ns/1ps
module lkp_ctrl_bench;
    localparam int NB = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [2:0]    req_blk = '0;
    logic          wp_lift = 1'b0;
    logic          abort = 1'b0;
    logic          clr_status = 1'b0;
    logic [CW-1:0] busy_len = '0;
    logic          busy;
    logic [7:0]    status;
    logic [NB-1:0] lock, lock_unk, done_mask;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [NB-1:0] m_lock = '0;
    logic [NB-1:0] m_unk = '0;
    bit e5 = 0, e4 = 0, e1 = 0;

    always #2.5 clk = ~clk;

    lkp_ctrl #(.NUM_BLK(NB), .CNT_W(CW)) u_lkp_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_blk_i(req_blk), .wp_lift_i(wp_lift), .abort_i(abort),
        .clr_status_i(clr_status), .busy_len_i(busy_len), .busy_o(busy),
        .status_o(status), .lock_o(lock), .lock_unknown_o(lock_unk),
        .done_o(done), .done_mask_o(done_mask)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_allowed(int op, int blk, bit wp);
        logic [NB-1:0] eff = m_lock | m_unk;
        case (op)
            1, 2: return !eff[blk] || wp;
            3:    return 1'b1;
            default: return wp;
        endcase
    endfunction

    function automatic logic [NB-1:0] exp_mask(int op, int blk, bit wp);
        logic [NB-1:0] eff = m_lock | m_unk;
        case (op)
            1, 2: return NB'(1) << blk;
            3:    return wp ? '1 : ~eff;
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {1'b1, 1'b0, e5, e4, 2'b00, e1, 1'b0};
    endfunction

    task automatic check_state(string req);
        check({req, " lock"}, 32'(lock), 32'(m_lock | m_unk));
        check({req, " unknown"}, 32'(lock_unk), 32'(m_unk));
        check({req, " status"}, 32'(status), 32'(exp_status()));
    endtask

    // One operation: abort_at 0 means no abort, otherwise the busy cycle of the abort.
    task automatic do_op(string req, int op, int blk, bit wp, int len,
                         int abort_at, bit stray, bit clr_same);
        bit ok;
        logic [NB-1:0] mask;
        int eff_len;
        bit aborted;
        eff_len = (len == 0) ? 1 : len;
        @(negedge clk);
        ok = exp_allowed(op, blk, wp);
        mask = exp_mask(op, blk, wp);
        req_valid = 1'b1; req_op = 3'(op); req_blk = 3'(blk);
        wp_lift = wp; busy_len = CW'(len); clr_status = clr_same;
        @(negedge clk);
        req_valid = 1'b0; clr_status = 1'b0;
        if (clr_same) begin e5 = 0; e4 = 0; e1 = 0; end
        if (!ok) begin
            e1 = 1;
            if (op == 2 || op == 4) e4 = 1; else e5 = 1;
            check({req, " R13 busy after reject"}, 32'(busy), 0);
            check({req, " R13 no done"}, 32'(done), 0);
            check_state({req, " R13 R12"});
            return;
        end
        check({req, " R8 busy starts"}, 32'(busy), 1);
        aborted = 0;
        for (int k = 1; k <= eff_len; k++) begin
            if (busy !== 1'b1) check({req, " R8 busy held"}, 32'(busy), 1);
            if (k == abort_at) abort = 1'b1;
            if (stray && k == eff_len) begin
                req_valid = 1'b1; req_op = 3'd5; wp_lift = 1'b1; busy_len = CW'(3);
            end
            @(negedge clk);
            abort = 1'b0; req_valid = 1'b0;
            if (k == abort_at) begin aborted = 1; break; end
        end
        check({req, " R8 busy ends"}, 32'(busy), 0);
        if (aborted) begin
            check({req, " R10 R11 no done on abort"}, 32'(done), 0);
            if (op == 5) m_unk = '1;
        end else begin
            check({req, " R8 done pulse"}, 32'(done), 1);
            check({req, " R2 R5 done mask"}, 32'(done_mask), 32'(mask));
            if (op == 4) m_lock[blk] = 1'b1;
            if (op == 5) begin m_lock = '0; m_unk = '0; end
        end
        @(negedge clk);
        check({req, " R8 R9 single done"}, 32'(done), 0);
        check({req, " R9 stray ignored"}, 32'(busy), 0);
        check_state({req, " R6 R7 R10"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 status", 32'(status), 32'h80);
        check("R1 lock", 32'(lock), 0);
        check("R1 unknown", 32'(lock_unk), 0);
        check("R1 done", 32'(done), 0);

        do_op("R2 erase open wp0", 1, 3, 0, 2, 0, 0, 0);
        do_op("R6 set lock wp1", 4, 2, 1, 3, 0, 0, 0);
        do_op("R6 set lock wp0 reject", 4, 5, 0, 1, 0, 0, 0);
        do_op("R3 write locked wp0", 2, 2, 0, 2, 0, 0, 0);
        do_op("R3 erase locked wp0", 1, 2, 0, 2, 0, 0, 0);
        do_op("R4 write locked wp1", 2, 2, 1, 2, 0, 0, 0);
        do_op("R5 chip erase wp0", 3, 0, 0, 4, 0, 0, 0);
        do_op("R5 chip erase wp1", 3, 0, 1, 1, 0, 0, 0);
        do_op("R7 clear wp0 reject", 5, 0, 0, 2, 0, 0, 0);
        // R12 sticky then cleared
        @(negedge clk); check_state("R12 sticky");
        clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
        e5 = 0; e4 = 0; e1 = 0;
        check("R12 cleared", 32'(status), 32'h80);
        do_op("R12 reject with clear", 2, 2, 0, 1, 0, 0, 1);
        do_op("R10 abort clear", 5, 0, 1, 4, 2, 0, 0);
        do_op("R10 unknown reads locked", 2, 6, 0, 1, 0, 0, 0);
        do_op("R11 abort last cycle", 1, 6, 1, 3, 3, 0, 0);
        do_op("R7 clear wp1", 5, 0, 1, 3, 0, 1, 0);
        do_op("R8 zero length", 2, 1, 0, 0, 0, 0, 0);
        do_op("R9 stray while busy", 4, 7, 1, 2, 0, 1, 0);

        for (int i = 0; i < 400; i++) begin
            int op, blk, len, ab;
            bit wp;
            op  = 1 + int'($urandom % 5);
            blk = int'($urandom % NB);
            wp  = 1'($urandom % 2);
            len = int'($urandom % 6);
            ab  = ($urandom % 6 == 0) ? 1 + int'($urandom % ((len == 0) ? 1 : len)) : 0;
            do_op("random", op, blk, wp, len, ab, 1'($urandom % 4 == 0),
                  1'($urandom % 6 == 0));
            if ($urandom % 10 == 0) begin
                @(negedge clk); clr_status = 1'b1;
                @(negedge clk); clr_status = 1'b0;
                e5 = 0; e4 = 0; e1 = 0;
                check("R12 random clear", 32'(status), 32'h80);
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule